// File: doc/BRIEF.md
# Windowed Circular Register File

This block is a register file for a processor whose procedure calls pass arguments in registers without copying them. Its windowed registers are grouped in eights and the groups form a ring. A separate group of eight global registers sits outside the ring. A window pointer picks three neighbouring groups of the ring. Those three groups, together with the globals, make up the 32 logical registers that software addresses with 5-bit numbers.

Within a frame, the lowest window group holds incoming parameters and the values the frame returns to its caller. The middle group holds locals. The highest group holds outgoing arguments and the results that come back from a callee. A call moves the pointer forward by two groups, so the caller's outgoing group becomes the callee's incoming group. A return moves the pointer back by two groups.

The ring has room for only a limited number of resident frames. A call that would wrap onto an older frame's groups is refused and raises an overflow flag. A return with no resident caller is refused and raises an underflow flag. Saving frames to memory and reloading them belongs to a neighbouring unit, which reacts to these flags.

Top module: `rwin_regfile`

## Requirements
- R1: Logical registers 0 to 7 always reach the same eight global registers, whatever the window position.
- R2: Logical registers 8-15, 16-23 and 24-31 reach ring groups (P), (P+1) and (P+2) modulo NUM_GROUPS, where P is the current window pointer. The register within a group is given by the low three address bits.
- R3: An accepted call advances the pointer by two groups on the clock edge. After it, the value the caller held in logical register 24+k reads back as logical register 8+k.
- R4: An accepted return moves the pointer back by two groups on the clock edge. After it, the value the callee held in logical register 8+k reads back as logical register 24+k.
- R5: At most (NUM_GROUPS-3)/2 frames may be resident above the base frame, which is 2 with 8 groups. A call made at that depth drives `win_ovf_o` high in the same cycle and leaves the pointer where it was.
- R6: A return made with no resident caller frame drives `win_unf_o` high in the same cycle and leaves the pointer where it was.
- R7: A write lands on the rising edge at the register its logical number selects under the pointer in force during that cycle. A call or return in the same cycle moves the pointer only after the write.
- R8: Both read ports are combinational and independent. Reading the register that is being written in the same cycle returns its old value.
- R9: A call and a return asserted in the same cycle cancel each other: the pointer does not move and neither flag rises.
- R10: A synchronous active-low reset sets the pointer to group 0, clears the resident depth and zeroes every register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| rd_a_addr_i | input | 5 | Logical register number for read port A |
| rd_a_data_o | output | DATA_W | Read port A data, combinational |
| rd_b_addr_i | input | 5 | Logical register number for read port B |
| rd_b_data_o | output | DATA_W | Read port B data, combinational |
| wr_en_i | input | 1 | Write enable |
| wr_addr_i | input | 5 | Logical register number to write |
| wr_data_i | input | DATA_W | Write data |
| call_i | input | 1 | Call strobe: advance the window |
| ret_i | input | 1 | Return strobe: retreat the window |
| win_ovf_o | output | 1 | Call refused because the ring is full |
| win_unf_o | output | 1 | Return refused because no caller frame is resident |

## Verification
The bench builds the block with 8 groups and 16-bit data. At that size the depth limit of two resident frames is reached after only two calls, so the bench can exercise both refusal flags, and every legal pointer position, within a few cycles. A narrow data path keeps the marker values easy to read while still telling apart all 72 physical registers. A behavioural model with its own arrays and counters predicts both read ports and both flags in every cycle. This covers the directed corner cases and a long stretch of mixed calls, returns and writes.

// File: rtl/rwin_pkg.sv
// Package rwin_pkg
// Shared constants for the windowed register file.
// Assumes: 5-bit logical register numbers and groups of eight registers.
package rwin_pkg;
    localparam int LREG_W    = 5;
    localparam int GRP_SIZE  = 8;
    localparam int GRP_OFS_W = 3;
    localparam int NUM_GLOB  = 8;
    typedef logic [LREG_W-1:0] lreg_t;
endpackage

// File: rtl/rwin_ptr.sv
// Module rwin_ptr
// Keeps the current window pointer and the count of resident frames.
// Decides whether a call or a return is accepted, and raises the
// overflow or underflow flag when it is refused.
// Assumes: NUM_GROUPS >= 5 and the pointer moves by two groups per frame.
module rwin_ptr #(
    parameter int NUM_GROUPS = 8,
    localparam int GW        = $clog2(NUM_GROUPS),
    localparam int MAX_DEPTH = (NUM_GROUPS - 3) / 2,
    localparam int DW        = (MAX_DEPTH < 1) ? 1 : $clog2(MAX_DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          call_i,
    input  logic          ret_i,
    output logic [GW-1:0] cwp_o,
    output logic          ovf_o,
    output logic          unf_o
);
    logic [GW-1:0] cwp_q;
    logic [DW-1:0] depth_q;
    logic          full, empty, do_call, do_ret;
    logic [GW-1:0] cwp_fwd, cwp_bwd;

    // Decode the strobes against the resident depth.
    always_comb begin
        full    = (int'(depth_q) == MAX_DEPTH);
        empty   = (depth_q == '0);
        do_call = call_i && !ret_i && !full;
        do_ret  = ret_i && !call_i && !empty;
        ovf_o   = call_i && !ret_i && full;
        unf_o   = ret_i && !call_i && empty;
    end

    // Compute the neighbouring pointer positions modulo the ring size.
    always_comb begin
        cwp_fwd = GW'((int'(cwp_q) + 2) % NUM_GROUPS);
        cwp_bwd = GW'((int'(cwp_q) + NUM_GROUPS - 2) % NUM_GROUPS);
    end

    // Pointer and depth registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cwp_q   <= '0;
            depth_q <= '0;
        end else if (do_call) begin
            cwp_q   <= cwp_fwd;
            depth_q <= depth_q + 1'b1;
        end else if (do_ret) begin
            cwp_q   <= cwp_bwd;
            depth_q <= depth_q - 1'b1;
        end
    end

    assign cwp_o = cwp_q;

    // R10
    reset_ptr_chk: assert property (@(posedge clk)
        !rst_n |=> (cwp_q == '0 && depth_q == '0));
    // R3
    call_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (call_i && !ret_i && !ovf_o) |=>
            int'(cwp_q) == (int'($past(cwp_q)) + 2) % NUM_GROUPS);
    // R4
    ret_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_i && !call_i && !unf_o) |=>
            int'(cwp_q) == (int'($past(cwp_q)) + NUM_GROUPS - 2) % NUM_GROUPS);
    // R5
    ovf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |=> $stable(cwp_q));
    // R5
    depth_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(depth_q) <= MAX_DEPTH);
    // R6
    unf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        unf_o |=> $stable(cwp_q));
    // R9
    both_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (call_i && ret_i) |=> ($stable(cwp_q) && $stable(depth_q)));
    // R5 R6
    flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ovf_o, unf_o}));
endmodule

// File: rtl/rwin_xlate.sv
// Module rwin_xlate
// Turns a logical register number into a physical storage index.
// Physical 0..7 are the globals, and ring group g starts at 8 + 8*g.
// Assumes: the pointer is below NUM_GROUPS.
module rwin_xlate
    import rwin_pkg::*;
#(
    parameter int NUM_GROUPS = 8,
    localparam int GW        = $clog2(NUM_GROUPS),
    localparam int PHYS      = NUM_GLOB + NUM_GROUPS * GRP_SIZE,
    localparam int PW        = $clog2(PHYS)
) (
    input  lreg_t         lreg_i,
    input  logic [GW-1:0] cwp_i,
    output logic [PW-1:0] phys_o
);
    int grp;

    // Select the global or the window group and add the register offset.
    always_comb begin
        grp = (int'(cwp_i) + int'(lreg_i[4:3]) - 1) % NUM_GROUPS;
        if (lreg_i[4:3] == 2'b00)
            phys_o = PW'(lreg_i[GRP_OFS_W-1:0]);
        else
            phys_o = PW'(NUM_GLOB + grp * GRP_SIZE + int'(lreg_i[GRP_OFS_W-1:0]));
    end

    // R2
    always_comb begin
        phys_range_chk: assert (int'(phys_o) < PHYS || $isunknown(lreg_i) || $isunknown(cwp_i));
    end
endmodule

// File: rtl/rwin_store.sv
// Module rwin_store
// Flat physical storage: one write port, two combinational read ports.
// Reads return the contents held before the current edge, with no bypass.
// Assumes: all indices have already been translated.
module rwin_store #(
    parameter int DATA_W = 32,
    parameter int PHYS   = 72,
    localparam int PW    = $clog2(PHYS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [PW-1:0]     widx_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [PW-1:0]     ridx_a_i,
    input  logic [PW-1:0]     ridx_b_i,
    output logic [DATA_W-1:0] rdata_a_o,
    output logic [DATA_W-1:0] rdata_b_o
);
    logic [DATA_W-1:0] mem_q [PHYS];

    // Clear every entry on reset, otherwise perform the single write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < PHYS; i++) mem_q[i] <= '0;
        end else if (we_i) begin
            mem_q[widx_i] <= wdata_i;
        end
    end

    // Combinational reads of the stored contents.
    assign rdata_a_o = mem_q[ridx_a_i];
    assign rdata_b_o = mem_q[ridx_b_i];

    // R7
    write_land_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |=> mem_q[$past(widx_i)] == $past(wdata_i));
endmodule

// File: rtl/rwin_regfile.sv
// Module rwin_regfile
// Top of the windowed register file. It joins the pointer control, three
// address translators (two read ports and one write port) and the storage.
// Assumes: the caller handles frame save and restore when a flag rises.
module rwin_regfile
    import rwin_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int NUM_GROUPS = 8,
    localparam int GW        = $clog2(NUM_GROUPS),
    localparam int PHYS      = NUM_GLOB + NUM_GROUPS * GRP_SIZE,
    localparam int PW        = $clog2(PHYS),
    localparam int NPORT     = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [4:0]        rd_a_addr_i,
    output logic [DATA_W-1:0] rd_a_data_o,
    input  logic [4:0]        rd_b_addr_i,
    output logic [DATA_W-1:0] rd_b_data_o,
    input  logic              wr_en_i,
    input  logic [4:0]        wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              call_i,
    input  logic              ret_i,
    output logic              win_ovf_o,
    output logic              win_unf_o
);
    logic [GW-1:0] cwp;
    lreg_t         lreg  [NPORT];
    logic [PW-1:0] pidx  [NPORT];

    assign lreg[0] = rd_a_addr_i;
    assign lreg[1] = rd_b_addr_i;
    assign lreg[2] = wr_addr_i;

    rwin_ptr #(.NUM_GROUPS(NUM_GROUPS)) u_ptr (
        .clk    (clk),
        .rst_n  (rst_n),
        .call_i (call_i),
        .ret_i  (ret_i),
        .cwp_o  (cwp),
        .ovf_o  (win_ovf_o),
        .unf_o  (win_unf_o)
    );

    // One translator per port, all using the pointer of the current cycle.
    for (genvar p = 0; p < NPORT; p++) begin : g_xl
        rwin_xlate #(.NUM_GROUPS(NUM_GROUPS)) u_xl (
            .lreg_i (lreg[p]),
            .cwp_i  (cwp),
            .phys_o (pidx[p])
        );
    end

    rwin_store #(.DATA_W(DATA_W), .PHYS(PHYS)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .we_i      (wr_en_i),
        .widx_i    (pidx[2]),
        .wdata_i   (wr_data_i),
        .ridx_a_i  (pidx[0]),
        .ridx_b_i  (pidx[1]),
        .rdata_a_o (rd_a_data_o),
        .rdata_b_o (rd_b_data_o)
    );
endmodule

// File: tb/tb_rwin_regfile.sv
module tb_rwin_regfile;
    localparam int DW = 16;
    localparam int NG = 8;
    localparam int MAXD = (NG - 3) / 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [4:0] ra = '0, rb = '0, wa = '0;
    logic [DW-1:0] wd = '0;
    logic we = 1'b0, c = 1'b0, r = 1'b0;
    logic [DW-1:0] rda, rdb;
    logic ovf, unf;

    int checks = 0, errors = 0;
    bit done = 1'b0;

    // Model state
    logic [DW-1:0] m_glob [8];
    logic [DW-1:0] m_ring [NG*8];
    int m_cwp, m_dep;

    always #10 clk = ~clk;

    rwin_regfile #(.DATA_W(DW), .NUM_GROUPS(NG)) dut (
        .clk(clk), .rst_n(rst_n),
        .rd_a_addr_i(ra), .rd_a_data_o(rda),
        .rd_b_addr_i(rb), .rd_b_data_o(rdb),
        .wr_en_i(we), .wr_addr_i(wa), .wr_data_i(wd),
        .call_i(c), .ret_i(r),
        .win_ovf_o(ovf), .win_unf_o(unf)
    );

    function automatic logic [DW-1:0] mread(input logic [4:0] a);
        int g;
        if (a < 8) return m_glob[a];
        g = (m_cwp + (a / 8) - 1) % NG;
        return m_ring[g*8 + (a % 8)];
    endfunction

    task automatic mwrite(input logic [4:0] a, input logic [DW-1:0] d);
        int g;
        if (a < 8) m_glob[a] = d;
        else begin
            g = (m_cwp + (a / 8) - 1) % NG;
            m_ring[g*8 + (a % 8)] = d;
        end
    endtask

    task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic mreset();
        for (int i = 0; i < 8; i++) m_glob[i] = '0;
        for (int i = 0; i < NG*8; i++) m_ring[i] = '0;
        m_cwp = 0;
        m_dep = 0;
    endtask

    // One clock: drive, compare before the edge, then advance the model.
    task automatic step(input logic iwe, input logic [4:0] iwa, input logic [DW-1:0] iwd,
                        input logic [4:0] ira, input logic [4:0] irb,
                        input logic ic, input logic ir, input string tag);
        logic eo, eu;
        @(negedge clk);
        we = iwe; wa = iwa; wd = iwd; ra = ira; rb = irb; c = ic; r = ir;
        #5;
        eo = ic && !ir && (m_dep == MAXD);
        eu = ir && !ic && (m_dep == 0);
        chk({tag, " port A"}, rda, mread(ira));
        chk({tag, " port B"}, rdb, mread(irb));
        chk("R5 overflow flag", DW'(ovf), DW'(eo));
        chk("R6 underflow flag", DW'(unf), DW'(eu));
        if (iwe) mwrite(iwa, iwd);
        if (ic && !ir && !eo) begin m_cwp = (m_cwp + 2) % NG; m_dep++; end
        if (ir && !ic && !eu) begin m_cwp = (m_cwp + NG - 2) % NG; m_dep--; end
    endtask

    task automatic rd(input logic [4:0] a, input logic [4:0] b, input string tag);
        step(1'b0, 5'd0, '0, a, b, 1'b0, 1'b0, tag);
    endtask

    task automatic wr(input logic [4:0] a, input logic [DW-1:0] d, input string tag);
        step(1'b1, a, d, a, 5'd0, 1'b0, 1'b0, tag);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        mreset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        // R10: all logical registers read zero after reset
        for (int a = 0; a < 32; a += 2) rd(5'(a), 5'(a+1), "R10 reset zero");
        // R1 and R2: fill globals and the window
        wr(5'd3, 16'h00A1, "R1 global write");
        for (int a = 8; a < 32; a++) wr(5'(a), DW'(16'h0100 + a), "R2 window write");
        for (int a = 0; a < 32; a += 2) rd(5'(a), 5'(a+1), "R2 window map");
        // R3: call, outgoing group becomes incoming group
        step(1'b0, 5'd0, '0, 5'd8, 5'd3, 1'b1, 1'b0, "R3 call cycle");
        for (int k = 0; k < 8; k++) rd(5'(8+k), 5'(16+k), "R3 shared group");
        rd(5'd3, 5'd24, "R1 global after call");
        // R4: callee writes a return value then returns
        wr(5'd9, 16'h0055, "R4 callee write");
        step(1'b0, 5'd0, '0, 5'd25, 5'd9, 1'b0, 1'b1, "R4 return cycle");
        rd(5'd25, 5'd9, "R4 return value");
        // R6: return at base depth refused
        step(1'b0, 5'd0, '0, 5'd8, 5'd24, 1'b0, 1'b1, "R6 underflow");
        rd(5'd8, 5'd24, "R6 pointer held");
        // R5: two calls fill the ring, the third is refused
        step(1'b0, 5'd0, '0, 5'd8, 5'd8, 1'b1, 1'b0, "R5 call 1");
        wr(5'd16, 16'h0AAA, "R5 mark local");
        step(1'b0, 5'd0, '0, 5'd8, 5'd8, 1'b1, 1'b0, "R5 call 2");
        step(1'b0, 5'd0, '0, 5'd8, 5'd8, 1'b1, 1'b0, "R5 call refused");
        rd(5'd8, 5'd16, "R5 pointer held");
        step(1'b0, 5'd0, '0, 5'd16, 5'd8, 1'b0, 1'b1, "R4 return 1");
        rd(5'd16, 5'd24, "R4 local restored");
        step(1'b0, 5'd0, '0, 5'd8, 5'd8, 1'b0, 1'b1, "R4 return 2");
        // R7: write and call in the same cycle use the old pointer
        step(1'b1, 5'd24, 16'h0077, 5'd24, 5'd8, 1'b1, 1'b0, "R7 write with call");
        rd(5'd8, 5'd24, "R7 write before move");
        step(1'b1, 5'd8, 16'h0066, 5'd8, 5'd24, 1'b0, 1'b1, "R7 write with return");
        rd(5'd24, 5'd8, "R7 write before return");
        // R8: read of the register being written returns the old value
        step(1'b1, 5'd5, 16'h0099, 5'd5, 5'd5, 1'b0, 1'b0, "R8 old value");
        rd(5'd5, 5'd3, "R8 new value");
        // R9: call and return together do nothing
        step(1'b0, 5'd0, '0, 5'd8, 5'd24, 1'b1, 1'b1, "R9 both strobes");
        rd(5'd8, 5'd24, "R9 pointer held");
        step(1'b0, 5'd0, '0, 5'd8, 5'd24, 1'b1, 1'b0, "R9 call after");
        step(1'b0, 5'd0, '0, 5'd8, 5'd24, 1'b1, 1'b1, "R9 both at depth 1");
        rd(5'd8, 5'd24, "R9 depth held");
        // R2: mixed traffic
        for (int i = 0; i < 600; i++) begin
            int x;
            x = int'($urandom % 100);
            step(($urandom % 2) == 1, 5'($urandom % 32), DW'($urandom),
                 5'($urandom % 32), 5'($urandom % 32),
                 x < 15, (x >= 12 && x < 30), "R2 mixed");
        end
        // R10: reset mid-run clears everything
        @(negedge clk); rst_n = 1'b0;
        @(posedge clk); #1;
        mreset();
        @(negedge clk); rst_n = 1'b1;
        for (int a = 0; a < 32; a += 2) rd(5'(a), 5'(a+1), "R10 reset again");
        step(1'b0, 5'd0, '0, 5'd8, 5'd8, 1'b0, 1'b1, "R10 depth cleared");
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule